// File: doc/BRIEF.md
# Audio Sample Alignment Packer

This block sits between a 32-bit AXI4-Stream data path and the parallel sample port of a serial audio shifter. It lets software move audio in whatever memory layout suits it without reshuffling bits on the CPU. The transmit direction takes stream words and turns them into one sample per beat for the shifter. The receive direction takes samples from the shifter and builds stream words from them.

The sample width can be 8, 16, 18, 20, 24 or 32 bits. In the one-sample-per-word layout, a sample sits either at the top of its 32-bit container, with zeros below it, or at the bottom, sign-extended above it. In the dense layout, samples follow one another least significant bit first and may cross a word boundary. The stream `tlast` flag marks the end of a transfer in both directions.

The configuration inputs are sampled only during reset or a synchronous clear. A clear also discards any bits still held between words.

Top module: `aud_sample_aligner`

## Requirements
- R1: After reset, both output valids are low and both input readies are high while the downstream readies are high.
- R2: The width code on `cfg_width` selects the sample width as follows: 0 gives 8 bits, 1 gives 16, 2 gives 18, 3 gives 20, 4 gives 24, and any other code gives 32.
- R3: In the one-sample-per-word layout with top placement (`cfg_right`=0), a received sample of width W appears with its MSB at stream bit 31. The low 32-W bits are zero.
- R4: In the one-sample-per-word layout with bottom placement (`cfg_right`=1), a received sample occupies stream bits W-1:0. Bit W-1 is copied into every bit above it. The stream `tlast` equals the sample's last flag.
- R5: In the one-sample-per-word layout, a transmit word yields one sample. With top placement the sample is bits 31:32-W, and with bottom placement it is bits W-1:0. Sample bits at W and above are zero, and the sample last flag equals `tlast`.
- R6: In the dense layout (`cfg_dense`=1), received samples are placed back to back starting at stream bit 0 of the first word. Each sample is stored LSB first, and a sample that does not fit continues at bit 0 of the next word. No word is sent until it is full or flushed.
- R7: In the dense layout, the receive sample marked last forces out the partially filled word with its unused upper bits zero. `tlast` is set only on the final word of that transfer.
- R8: In the dense layout, transmit words are split LSB first into W-bit samples, including samples that cross a word boundary. Leftover bits fewer than W after a `tlast` word are dropped. The sample last flag is set only on the final sample of that word's transfer.
- R9: An output whose valid is high while its ready is low keeps its data and last flag unchanged. No sample or word is lost or repeated under backpressure.
- R10: A change on the configuration inputs has no effect until the next cycle in which `cfg_clear` is high.
- R11: While `cfg_clear` is high, both input readies are low. After a clear cycle, both output valids are low and any residual bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clear | input | 1 | Synchronous clear; also captures configuration |
| cfg_width | input | 3 | Sample width code |
| cfg_right | input | 1 | 1 = bottom placement, 0 = top placement (one-per-word layout) |
| cfg_dense | input | 1 | 1 = dense back-to-back layout |
| s_axis_tdata | input | 32 | Transmit stream data |
| s_axis_tvalid | input | 1 | Transmit stream valid |
| s_axis_tready | output | 1 | Transmit stream ready |
| s_axis_tlast | input | 1 | Transmit stream end of transfer |
| tx_smp_data | output | 32 | Sample to shifter, right aligned, zero above width |
| tx_smp_valid | output | 1 | Sample to shifter valid |
| tx_smp_ready | input | 1 | Shifter accepts sample |
| tx_smp_last | output | 1 | Final sample of transfer |
| rx_smp_data | input | 32 | Sample from shifter, low W bits used |
| rx_smp_valid | input | 1 | Sample from shifter valid |
| rx_smp_ready | output | 1 | Block accepts sample |
| rx_smp_last | input | 1 | Final sample of transfer |
| m_axis_tdata | output | 32 | Receive stream data |
| m_axis_tvalid | output | 1 | Receive stream valid |
| m_axis_tready | input | 1 | Receive stream ready |
| m_axis_tlast | output | 1 | Receive stream end of transfer |

## Verification
The bench covers samples that straddle a word boundary in both directions. A packer that got this wrong would lose or misplace the carried bits. It also covers a final dense word that is only partly full, which a broken design would leave unsent, fill with stale bits or flag at the wrong word. Further cases are negative samples with bottom placement, which expose missing sign extension, and random backpressure on both outputs, which catches a word dropped or sent twice while ready is low. Finally, the bench changes the configuration without a clear and clears while residual bits are held. A design that applied settings at once, or kept old bits across a clear, would emit values that differ from the scoreboard.

// File: rtl/aud_align_pkg.sv
package aud_align_pkg;
  localparam int AW_WORD = 32;
  localparam int AW_SW   = $clog2(AW_WORD + 1);

  typedef struct packed {
    logic [AW_SW-1:0] width;
    logic             right;
    logic             dense;
  } align_cfg_t;

  function automatic logic [AW_SW-1:0] decode_width(input logic [2:0] code);
    case (code)
      3'd0:    return AW_SW'(8);
      3'd1:    return AW_SW'(16);
      3'd2:    return AW_SW'(18);
      3'd3:    return AW_SW'(20);
      3'd4:    return AW_SW'(24);
      default: return AW_SW'(AW_WORD);
    endcase
  endfunction
endpackage

// File: rtl/aud_cfg_hold.sv
module aud_cfg_hold
  import aud_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [2:0] width_code,
  input  logic       right,
  input  logic       dense,
  output align_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cfg.width <= decode_width(width_code);
      cfg.right <= right;
      cfg.dense <= dense;
    end
  end
endmodule

// File: rtl/aud_rx_packer.sv
module aud_rx_packer
  import aud_align_pkg::*;
#(
  parameter int WORD_W = AW_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  align_cfg_t        cfg,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic              smp_last,
  output logic              smp_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_last,
  input  logic              m_ready
);
  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam int SW_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic [BUF_W-1:0]  acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              flush_q, flush_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              valid_q, valid_n, last_q, last_n;
  logic              can_load, take, ready_c;
  logic [WORD_W-1:0] smp_mask, smp_clean, single_word;
  logic              smp_sign;

  assign can_load  = !valid_q || m_ready;
  assign smp_mask  = (cfg.width >= SW_W'(WORD_W)) ? '1
                   : ((WORD_W'(1) << cfg.width) - WORD_W'(1));
  assign smp_clean = smp_data & smp_mask;
  assign smp_sign  = |(smp_clean & smp_mask & ~(smp_mask >> 1));

  always_comb begin
    if (cfg.right) single_word = smp_clean | (smp_sign ? ~smp_mask : '0);
    else           single_word = smp_clean << (SW_W'(WORD_W) - cfg.width);
  end

  always_comb begin
    acc_n   = acc_q;
    cnt_n   = cnt_q;
    flush_n = flush_q;
    word_n  = word_q;
    last_n  = last_q;
    valid_n = valid_q && !m_ready;
    ready_c = 1'b0;
    take    = 1'b0;
    if (!cfg.dense) begin
      ready_c = can_load && !clr;
      take    = smp_valid && ready_c;
      if (take) begin
        valid_n = 1'b1;
        word_n  = single_word;
        last_n  = smp_last;
      end
    end else begin
      if (can_load && (cnt_q >= WORD_CNT || (flush_q && cnt_q != '0))) begin
        valid_n = 1'b1;
        word_n  = acc_q[WORD_W-1:0];
        last_n  = flush_q && (cnt_q <= WORD_CNT);
        acc_n   = acc_q >> WORD_W;
        cnt_n   = (cnt_q >= WORD_CNT) ? cnt_q - WORD_CNT : '0;
        if (last_n) begin
          flush_n = 1'b0;
          acc_n   = '0;
          cnt_n   = '0;
        end
      end
      ready_c = !clr && !flush_q && (cnt_n < WORD_CNT);
      take    = smp_valid && ready_c;
      if (take) begin
        acc_n   = acc_n | (BUF_W'(smp_clean) << cnt_n);
        cnt_n   = cnt_n + CNT_W'(cfg.width);
        flush_n = smp_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      cnt_q   <= cnt_n;
      flush_q <= flush_n;
      word_q  <= word_n;
      valid_q <= valid_n;
      last_q  <= last_n;
    end
  end

  assign smp_ready = ready_c;
  assign m_data    = word_q;
  assign m_valid   = valid_q;
  assign m_last    = last_q;
endmodule

// File: rtl/aud_tx_unpacker.sv
module aud_tx_unpacker
  import aud_align_pkg::*;
#(
  parameter int WORD_W = AW_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  align_cfg_t        cfg,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic [WORD_W-1:0] smp_data,
  output logic              smp_valid,
  output logic              smp_last,
  input  logic              smp_ready
);
  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam int SW_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic [BUF_W-1:0]  acc_q, acc_n, acc_mid;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_mid, w_cnt;
  logic              have_q, have_n, have_mid;
  logic [WORD_W-1:0] out_q, out_n, smp_mask;
  logic              valid_q, valid_n, last_q, last_n;
  logic              can_load, ready_c, take;

  assign can_load = !valid_q || smp_ready;
  assign w_cnt    = CNT_W'(cfg.width);
  assign smp_mask = (cfg.width >= SW_W'(WORD_W)) ? '1
                  : ((WORD_W'(1) << cfg.width) - WORD_W'(1));

  always_comb begin
    acc_n    = acc_q;
    cnt_n    = cnt_q;
    have_n   = have_q;
    acc_mid  = acc_q;
    cnt_mid  = cnt_q;
    have_mid = have_q;
    out_n    = out_q;
    last_n   = last_q;
    valid_n  = valid_q && !smp_ready;
    ready_c  = 1'b0;
    take     = 1'b0;
    if (!cfg.dense) begin
      ready_c = can_load && !clr;
      take    = s_valid && ready_c;
      if (take) begin
        valid_n = 1'b1;
        out_n   = cfg.right ? (s_data & smp_mask)
                            : (s_data >> (SW_W'(WORD_W) - cfg.width));
        last_n  = s_last;
      end
    end else begin
      if (can_load && cnt_q >= w_cnt) begin
        valid_n = 1'b1;
        out_n   = acc_q[WORD_W-1:0] & smp_mask;
        last_n  = have_q && ((cnt_q - w_cnt) < w_cnt);
        acc_mid = acc_q >> cfg.width;
        cnt_mid = cnt_q - w_cnt;
        if (last_n) begin
          acc_mid  = '0;
          cnt_mid  = '0;
          have_mid = 1'b0;
        end
      end
      ready_c = !clr && !have_mid && (cnt_mid <= WORD_CNT);
      take    = s_valid && ready_c;
      acc_n   = acc_mid;
      cnt_n   = cnt_mid;
      have_n  = have_mid;
      if (take) begin
        acc_n  = acc_mid | (BUF_W'(s_data) << cnt_mid);
        cnt_n  = cnt_mid + WORD_CNT;
        have_n = s_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      have_q  <= 1'b0;
      out_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      cnt_q   <= cnt_n;
      have_q  <= have_n;
      out_q   <= out_n;
      valid_q <= valid_n;
      last_q  <= last_n;
    end
  end

  assign s_ready   = ready_c;
  assign smp_data  = out_q;
  assign smp_valid = valid_q;
  assign smp_last  = last_q;
endmodule

// File: rtl/aud_sample_aligner.sv
module aud_sample_aligner
  import aud_align_pkg::*;
#(
  parameter int WORD_W = AW_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_clear,
  input  logic [2:0]        cfg_width,
  input  logic              cfg_right,
  input  logic              cfg_dense,
  input  logic [WORD_W-1:0] s_axis_tdata,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  input  logic              s_axis_tlast,
  output logic [WORD_W-1:0] tx_smp_data,
  output logic              tx_smp_valid,
  input  logic              tx_smp_ready,
  output logic              tx_smp_last,
  input  logic [WORD_W-1:0] rx_smp_data,
  input  logic              rx_smp_valid,
  output logic              rx_smp_ready,
  input  logic              rx_smp_last,
  output logic [WORD_W-1:0] m_axis_tdata,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic              m_axis_tlast
);
  align_cfg_t       act_cfg;
  logic [AW_SW-1:0] act_width;
  logic             act_right, act_dense;

  aud_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .clr(cfg_clear),
    .width_code(cfg_width), .right(cfg_right), .dense(cfg_dense),
    .cfg(act_cfg)
  );

  assign act_width = act_cfg.width;
  assign act_right = act_cfg.right;
  assign act_dense = act_cfg.dense;

  aud_tx_unpacker #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .clr(cfg_clear), .cfg(act_cfg),
    .s_data(s_axis_tdata), .s_valid(s_axis_tvalid), .s_last(s_axis_tlast),
    .s_ready(s_axis_tready),
    .smp_data(tx_smp_data), .smp_valid(tx_smp_valid), .smp_last(tx_smp_last),
    .smp_ready(tx_smp_ready)
  );

  aud_rx_packer #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .clr(cfg_clear), .cfg(act_cfg),
    .smp_data(rx_smp_data), .smp_valid(rx_smp_valid), .smp_last(rx_smp_last),
    .smp_ready(rx_smp_ready),
    .m_data(m_axis_tdata), .m_valid(m_axis_tvalid), .m_last(m_axis_tlast),
    .m_ready(m_axis_tready)
  );
endmodule

// File: rtl/aud_align_checks.sv
module aud_align_checks #(
  parameter int WORD_W = 32,
  parameter int SW_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_clear,
  input logic              s_ready,
  input logic              rx_ready,
  input logic [WORD_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic [WORD_W-1:0] m_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_last,
  input logic [SW_W-1:0]   act_width,
  input logic              act_right,
  input logic              act_dense
);
  AST_M_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready && !cfg_clear) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !cfg_clear) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R9
  AST_TX_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && act_width < SW_W'(WORD_W)) |-> ((tx_data >> act_width) == '0)); // R5
  AST_RX_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !act_dense && !act_right) |-> (WORD_W'(m_data << act_width) == '0)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    cfg_clear |=> (!m_valid && !tx_valid)); // R11
  AST_CLEAR_STALLS: assert property (@(posedge clk) disable iff (rst)
    cfg_clear |-> (!s_ready && !rx_ready)); // R11
endmodule

bind aud_sample_aligner aud_align_checks #(.WORD_W(WORD_W), .SW_W(aud_align_pkg::AW_SW)) u_chk (
  .clk(clk), .rst(rst), .cfg_clear(cfg_clear),
  .s_ready(s_axis_tready), .rx_ready(rx_smp_ready),
  .tx_data(tx_smp_data), .tx_valid(tx_smp_valid), .tx_ready(tx_smp_ready), .tx_last(tx_smp_last),
  .m_data(m_axis_tdata), .m_valid(m_axis_tvalid), .m_ready(m_axis_tready), .m_last(m_axis_tlast),
  .act_width(act_width), .act_right(act_right), .act_dense(act_dense)
);

// File: tb/aud_sample_aligner_bench.sv
module aud_sample_aligner_bench;
  localparam int WORD_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1, cfg_clear = 1'b0;
  logic [2:0]        cfg_width = 3'd1;
  logic              cfg_right = 1'b0, cfg_dense = 1'b0;
  logic [WORD_W-1:0] s_axis_tdata = '0, rx_smp_data = '0;
  logic              s_axis_tvalid = 1'b0, s_axis_tlast = 1'b0, s_axis_tready;
  logic [WORD_W-1:0] tx_smp_data, m_axis_tdata;
  logic              tx_smp_valid, tx_smp_last, tx_smp_ready = 1'b1;
  logic              rx_smp_valid = 1'b0, rx_smp_last = 1'b0, rx_smp_ready;
  logic              m_axis_tvalid, m_axis_tlast, m_axis_tready = 1'b1;

  aud_sample_aligner u_aud_sample_aligner (.*);

  int    errors = 0, checks = 0;
  string cur_req = "R1";
  logic [31:0] exp_m_data[$], exp_t_data[$];
  bit          exp_m_last[$], exp_t_last[$];
  bit          rx_bits[$], tx_bits[$];
  int          cur_w = 16;
  bit          cur_right = 0, cur_dense = 0;
  bit          bp_on = 0, stall = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_axis_tready = stall ? 1'b0 : (bp_on ? lfsr[0] : 1'b1);
    tx_smp_ready  = bp_on ? lfsr[5] : 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wid(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 16; 3'd2: return 18;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] pop_rx(input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = rx_bits.pop_front();
    return v;
  endfunction

  function automatic logic [31:0] pop_tx(input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = tx_bits.pop_front();
    return v;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (m_axis_tvalid && m_axis_tready) begin
        if (exp_m_data.size() == 0) check({cur_req, " extra word"}, m_axis_tdata, 32'hDEAD_BEEF);
        else begin
          check(cur_req, m_axis_tdata, exp_m_data.pop_front());
          check({cur_req, " tlast"}, 32'(m_axis_tlast), 32'(exp_m_last.pop_front()));
        end
      end
      if (tx_smp_valid && tx_smp_ready) begin
        if (exp_t_data.size() == 0) check({cur_req, " extra sample"}, tx_smp_data, 32'hDEAD_BEEF);
        else begin
          check(cur_req, tx_smp_data, exp_t_data.pop_front());
          check({cur_req, " last"}, 32'(tx_smp_last), 32'(exp_t_last.pop_front()));
        end
      end
    end
  end

  task automatic do_clear(input logic [2:0] code, input bit right, input bit dense);
    cfg_width = code; cfg_right = right; cfg_dense = dense; cfg_clear = 1'b1;
    @(negedge clk);
    check("R11 ready low in clear", {30'd0, s_axis_tready, rx_smp_ready}, 32'd0);
    @(posedge clk); #1;
    cfg_clear = 1'b0;
    cur_w = wid(code); cur_right = right; cur_dense = dense;
    rx_bits.delete(); tx_bits.delete();
  endtask

  task automatic send_rx(input logic [31:0] s, input bit last);
    logic [31:0] m = wmask(cur_w);
    logic [31:0] c = s & m;
    if (!cur_dense) begin
      if (cur_right) exp_m_data.push_back(c | (c[cur_w-1] ? ~m : 32'd0));
      else           exp_m_data.push_back(c << (32 - cur_w));
      exp_m_last.push_back(last);
    end else begin
      for (int i = 0; i < cur_w; i++) rx_bits.push_back(c[i]);
      if (!last) begin
        while (rx_bits.size() >= 32) begin
          exp_m_data.push_back(pop_rx(32)); exp_m_last.push_back(1'b0);
        end
      end else begin
        while (rx_bits.size() > 0) begin
          int n = (rx_bits.size() >= 32) ? 32 : rx_bits.size();
          exp_m_data.push_back(pop_rx(n)); exp_m_last.push_back(rx_bits.size() == 0);
        end
      end
    end
    rx_smp_data = s; rx_smp_last = last; rx_smp_valid = 1'b1;
    forever begin @(negedge clk); if (rx_smp_ready) break; end
    @(posedge clk); #1;
    rx_smp_valid = 1'b0;
  endtask

  task automatic send_tx(input logic [31:0] w, input bit last);
    if (!cur_dense) begin
      exp_t_data.push_back(cur_right ? (w & wmask(cur_w)) : (w >> (32 - cur_w)));
      exp_t_last.push_back(last);
    end else begin
      for (int i = 0; i < 32; i++) tx_bits.push_back(w[i]);
      while (tx_bits.size() >= cur_w) begin
        exp_t_data.push_back(pop_tx(cur_w));
        exp_t_last.push_back(last && (tx_bits.size() < cur_w));
      end
      if (last) tx_bits.delete();
    end
    s_axis_tdata = w; s_axis_tlast = last; s_axis_tvalid = 1'b1;
    forever begin @(negedge clk); if (s_axis_tready) break; end
    @(posedge clk); #1;
    s_axis_tvalid = 1'b0;
  endtask

  task automatic drain();
    while (exp_m_data.size() != 0 || exp_t_data.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check("R1 valids after reset", {30'd0, m_axis_tvalid, tx_smp_valid}, 32'd0);
    check("R1 readies after reset", {30'd0, s_axis_tready, rx_smp_ready}, 32'd3);
    @(posedge clk); #1;

    // one-per-word, top placement
    do_clear(3'd1, 0, 0); cur_req = "R3 R2 w16";
    send_rx(32'h0000_8001, 0); send_rx(32'hFFFF_1234, 1);
    cur_req = "R5 w16 top";
    send_tx(32'hABCD_1234, 0); send_tx(32'h8000_0001, 1); drain();
    do_clear(3'd3, 0, 0); cur_req = "R3 R2 w20";
    send_rx(32'h000F_0F0F, 1);
    cur_req = "R5 w20 top"; send_tx(32'h1234_5678, 1); drain();

    // one-per-word, bottom placement
    do_clear(3'd4, 1, 0); cur_req = "R4 R2 w24";
    send_rx(32'h0080_0001, 0); send_rx(32'h0012_3456, 1);
    cur_req = "R5 w24 bottom"; send_tx(32'hABCD_EF12, 1); drain();
    do_clear(3'd2, 1, 0); cur_req = "R4 R2 w18";
    send_rx(32'h0002_0003, 1); send_rx(32'h0001_FFFF, 0);
    cur_req = "R5 w18 bottom"; send_tx(32'hFFFF_FFFF, 0); drain();
    do_clear(3'd7, 1, 0); cur_req = "R4 R2 w32";
    send_rx(32'h8765_4321, 1); cur_req = "R5 w32"; send_tx(32'h0BAD_F00D, 1); drain();

    // dense receive with backpressure
    bp_on = 1;
    do_clear(3'd4, 0, 1); cur_req = "R6 R7 R9 w24 dense";
    for (int i = 0; i < 5; i++) send_rx(32'h00A0_0000 + 32'(i * 32'h1111), i == 4);
    drain();
    do_clear(3'd2, 0, 1); cur_req = "R6 R7 R9 w18 dense";
    for (int i = 0; i < 7; i++) send_rx(32'h0002_5A5A ^ 32'(i * 32'h0313), i == 6);
    drain();
    do_clear(3'd0, 1, 1); cur_req = "R6 R7 w8 exact";
    for (int i = 0; i < 4; i++) send_rx(32'hC0 + 32'(i), i == 3);
    drain();
    do_clear(3'd5, 0, 1); cur_req = "R6 R7 w32 dense";
    send_rx(32'h1357_9BDF, 0); send_rx(32'h2468_ACE0, 1); drain();

    // dense transmit with backpressure
    do_clear(3'd3, 0, 1); cur_req = "R8 R9 w20 dense";
    send_tx(32'h0123_4567, 0); send_tx(32'h89AB_CDEF, 0); send_tx(32'hF0E1_D2C3, 1); drain();
    do_clear(3'd4, 1, 1); cur_req = "R8 R9 w24 dense";
    send_tx(32'hDEAD_BEEF, 0); send_tx(32'hCAFE_BABE, 0); send_tx(32'h1234_5678, 1); drain();
    do_clear(3'd2, 0, 1); cur_req = "R8 w18 dense";
    send_tx(32'hA5A5_5A5A, 0); send_tx(32'h3C3C_C3C3, 1);
    send_tx(32'h7777_1111, 1); drain();
    do_clear(3'd0, 0, 1); cur_req = "R8 w8 dense";
    send_tx(32'h0403_0201, 1); drain();
    bp_on = 0;

    // configuration only applies at a clear
    do_clear(3'd1, 0, 0);
    cfg_width = 3'd0; cfg_right = 1'b1;
    cur_req = "R10 no clear"; send_rx(32'h0000_80AB, 1); drain();
    do_clear(3'd0, 0, 0);
    cur_req = "R10 after clear"; send_rx(32'h0000_80AB, 1); drain();

    // clear discards residue
    do_clear(3'd0, 0, 1); cur_req = "R11 rx residue";
    send_rx(32'h11, 0);
    repeat (3) @(negedge clk);
    check("R6 R11 no partial word out", {31'd0, m_axis_tvalid}, 32'd0);
    @(posedge clk); #1;
    do_clear(3'd0, 0, 1);
    send_rx(32'h22, 1); drain();
    do_clear(3'd4, 0, 1); cur_req = "R11 tx residue";
    send_tx(32'h99AA_BBCC, 0); drain();
    do_clear(3'd4, 0, 1);
    send_tx(32'h0066_5544, 1); drain();

    // explicit hold under stall
    do_clear(3'd1, 0, 0); cur_req = "R9 stall";
    stall = 1; @(posedge clk); @(posedge clk); #1;
    send_rx(32'h0000_BEEF, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 held valid", {31'd0, m_axis_tvalid}, 32'd1);
      check("R9 held data", m_axis_tdata, 32'hBEEF_0000);
    end
    @(posedge clk); #1 stall = 0;
    drain();

    check("R9 scoreboard empty", 32'(exp_m_data.size() + exp_t_data.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done (%s)", cur_req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule